// File: doc/BRIEF.md
# Bit-Rate Prescaler with Scaled Idle-Line Timeout

This block derives the bit-time clock enable for a token-passing network controller from a single fast system clock, and watches the line for silence. The system clock runs at the doubled effective frequency (nominally 40 MHz). A clock-enable model of the frequency multiplier turns it into either a base-rate tick (one tick every two system cycles, standing for 20 MHz) or a doubled tick (every cycle). A prescaler then divides the tick by 8, 16, 32, 64 or 128. With the doubled clock, the divide-by-8 setting yields 5 Mbps. With the base clock, the five divisors yield 2.5 Mbps, 1.25 Mbps, 625 Kbps, 312.5 Kbps and 156.25 Kbps. Together these give six data rates.

The idle-line timer counts bit-time enables rather than system cycles, so its wall-clock length scales with the selected rate. The default of 205 bit times is 41 µs at 5 Mbps and roughly 1.3 ms at 156.25 Kbps, which is a scaling factor of 32. Any cycle with line activity restarts the timer. Once it expires, the timeout flag stays high until activity returns.

Rate and multiplier settings are taken into use only when the prescaler wraps. A setting change therefore never shortens or stretches a bit period that is in progress.

Top module: `bitrate_prescaler`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, `bitEn` and `idleTimeout` are both low.
- R2: With multiplier code 0, rate code k (0 to 4) gives `bitEn` pulses spaced 2 × (8 << k) system cycles apart.
- R3: Rate codes 5, 6 and 7 behave exactly like rate code 4 (division by 128).
- R4: Multiplier code 1 (doubled clock) gives a pulse spacing of (8 << k) system cycles for rate code k.
- R5: The reserved multiplier codes 2 and 3 give the same spacing as code 0.
- R6: Each `bitEn` pulse is exactly one system cycle wide.
- R7: A change of `rateSel` or `mulSel` leaves the bit period in progress unchanged. The new spacing applies from the next `bitEn` pulse onward.
- R8: `idleTimeout` rises one cycle after the IDLE_BITS-th `bitEn` pulse that follows the last cycle in which `lineActive` was high. A pulse in a cycle with `lineActive` high is not counted.
- R9: Once high, `idleTimeout` stays high while `lineActive` stays low. It is low in the cycle after a cycle in which `lineActive` was high.
- R10: When `lineActive` and a `bitEn` pulse fall in the same cycle, the activity wins. The flag does not rise, and a full IDLE_BITS further pulses are needed before it rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at the doubled effective frequency |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | RATE_W | Rate code; 0 to 4 select divide by 8 to 128, higher codes clamp to 128 |
| mulSel | input | MUL_W | Multiplier code; 1 selects the doubled clock, all others the base clock |
| lineActive | input | 1 | High in any cycle where line activity is seen |
| bitEn | output | 1 | One-cycle bit-time enable pulse |
| idleTimeout | output | 1 | High once the scaled idle period has elapsed without activity |

## Verification
The prescaler wrap that produces a bit-time pulse can fall in the same cycle as line activity. In that cycle, the pulse must not advance the idle timer, and the activity must restart it. The bench provokes this case by counting pulses up to the one that would expire the timer, then raising `lineActive` during the very cycle in which that pulse is visible. It then judges the outcome at the ports: the flag must stay low in the next cycle, and it must rise only after a complete fresh run of IDLE_BITS pulses. A second coincidence also gets a directed test. A setting change is applied in the cycle right after a wrap, and the bench measures that the old period completes unchanged before the new one begins.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;

  // Strobes from the control to the datapath, one cycle each
  typedef struct packed {
    logic tick;       // effective-clock enable for the prescaler
    logic reload;     // prescaler wraps: reload count, emit bit enable
    logic idleStep;   // advance idle timer by one bit time
    logic idleClear;  // line activity: restart idle timer, drop flag
  } rateStrobes_t;

endpackage

// File: rtl/bitrate_ctrl.sv
module bitrate_ctrl
  import bitrate_pkg::*;
#(
  parameter int BASE_DIV_LOG2 = 3,
  parameter int RATE_STEPS    = 5,
  parameter int RATE_W        = 3,
  parameter int MUL_W         = 2,
  localparam int CNT_W        = BASE_DIV_LOG2 + RATE_STEPS - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [MUL_W-1:0]  mulSel,
  input  logic              lineActive,
  input  logic              cntZero,
  input  logic              bitEnQ,
  output rateStrobes_t      strobes,
  output logic [CNT_W-1:0]  reloadVal
);

  localparam logic [RATE_W-1:0] LAST_RATE  = RATE_W'(RATE_STEPS - 1);
  localparam logic [MUL_W-1:0]  MUL_DOUBLE = MUL_W'(1);

  logic [MUL_W-1:0]  activeMul;
  logic              phase;
  logic              useDouble;
  logic [RATE_W-1:0] rateClamped;
  logic [CNT_W:0]    divFull;

  // Multiplier model: doubled clock ticks every cycle, all other codes every second cycle
  assign useDouble = (activeMul == MUL_DOUBLE);

  always_comb begin
    strobes.tick      = useDouble | phase;
    strobes.reload    = strobes.tick & cntZero;
    strobes.idleClear = lineActive;
    strobes.idleStep  = bitEnQ & ~lineActive;
  end

  // Divider for the incoming rate code, clamped to the slowest step
  always_comb begin
    rateClamped = (rateSel > LAST_RATE) ? LAST_RATE : rateSel;
    divFull     = (CNT_W+1)'(1) << (int'(rateClamped) + BASE_DIV_LOG2);
    reloadVal   = CNT_W'(divFull - (CNT_W+1)'(1));
  end

  // Settings are adopted only at a wrap; phase restarts so the new period is whole
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMul <= '0;
      phase     <= 1'b0;
    end else if (strobes.reload) begin
      activeMul <= mulSel;
      phase     <= 1'b0;
    end else begin
      phase     <= ~phase;
    end
  end

  // R7
  mul_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.reload |=> $stable(activeMul));

endmodule

// File: rtl/bitrate_dp.sv
module bitrate_dp
  import bitrate_pkg::*;
#(
  parameter int BASE_DIV_LOG2 = 3,
  parameter int RATE_STEPS    = 5,
  parameter int IDLE_BITS     = 205,
  localparam int CNT_W        = BASE_DIV_LOG2 + RATE_STEPS - 1,
  localparam int IDLE_W       = $clog2(IDLE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rateStrobes_t     strobes,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             cntZero,
  output logic             bitEn,
  output logic             idleTimeout
);

  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(IDLE_BITS - 1);

  logic [CNT_W-1:0]  preCnt;
  logic [IDLE_W-1:0] idleCnt;

  assign cntZero = (preCnt == '0);

  // Prescaler down-counter and bit-time enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      bitEn  <= 1'b0;
    end else begin
      bitEn <= strobes.reload;
      if (strobes.reload)    preCnt <= reloadVal;
      else if (strobes.tick) preCnt <= preCnt - 1'b1;
    end
  end

  // Idle timer in bit times; activity has priority over a step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt     <= '0;
      idleTimeout <= 1'b0;
    end else if (strobes.idleClear) begin
      idleCnt     <= '0;
      idleTimeout <= 1'b0;
    end else if (strobes.idleStep && !idleTimeout) begin
      idleCnt     <= idleCnt + 1'b1;
      idleTimeout <= (idleCnt == IDLE_LAST);
    end
  end

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |=> !bitEn);

  // R8
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleTimeout) |-> $past(strobes.idleStep));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idleTimeout && !strobes.idleClear) |=> idleTimeout);

  // R10
  clear_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.idleClear |=> (idleCnt == '0 && !idleTimeout));

endmodule

// File: rtl/bitrate_prescaler.sv
module bitrate_prescaler
  import bitrate_pkg::*;
#(
  parameter int BASE_DIV_LOG2 = 3,
  parameter int RATE_STEPS    = 5,
  parameter int IDLE_BITS     = 205,
  parameter int RATE_W        = 3,
  parameter int MUL_W         = 2,
  localparam int CNT_W        = BASE_DIV_LOG2 + RATE_STEPS - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [MUL_W-1:0]  mulSel,
  input  logic              lineActive,
  output logic              bitEn,
  output logic              idleTimeout
);

  rateStrobes_t     strobes;
  logic [CNT_W-1:0] reloadVal;
  logic             cntZero;

  bitrate_ctrl #(
    .BASE_DIV_LOG2(BASE_DIV_LOG2),
    .RATE_STEPS   (RATE_STEPS),
    .RATE_W       (RATE_W),
    .MUL_W        (MUL_W)
  ) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rateSel   (rateSel),
    .mulSel    (mulSel),
    .lineActive(lineActive),
    .cntZero   (cntZero),
    .bitEnQ    (bitEn),
    .strobes   (strobes),
    .reloadVal (reloadVal)
  );

  bitrate_dp #(
    .BASE_DIV_LOG2(BASE_DIV_LOG2),
    .RATE_STEPS   (RATE_STEPS),
    .IDLE_BITS    (IDLE_BITS)
  ) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .reloadVal  (reloadVal),
    .cntZero    (cntZero),
    .bitEn      (bitEn),
    .idleTimeout(idleTimeout)
  );

endmodule

// File: tb/bitrate_prescaler_test.sv
module bitrate_prescaler_test;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] rateSel = '0;
  logic [1:0] mulSel = 2'd1;
  logic       lineActive = 1'b0;
  logic       bitEn;
  logic       idleTimeout;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitrate_prescaler #(.IDLE_BITS(IDLE)) uut (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .mulSel(mulSel),
    .lineActive(lineActive), .bitEn(bitEn), .idleTimeout(idleTimeout)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until bitEn is seen high; returns the spacing in cycles
  task automatic waitPulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bitEn);
  endtask

  task automatic activity();
    lineActive = 1'b1;
    @(negedge clk);
    lineActive = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    string req;
    int exp;
    int rc;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 bitEn in reset", int'(bitEn), 0);
    check("R1 idleTimeout in reset", int'(idleTimeout), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 bitEn after release", int'(bitEn), 0);
    check("R1 idleTimeout after release", int'(idleTimeout), 0);

    // Sweep: every multiplier code against every rate code
    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 8; r++) begin
        rateSel = 3'(r);
        mulSel  = 2'(m);
        waitPulse(n);
        waitPulse(n);
        rc  = (r > 4) ? 4 : r;
        exp = ((m == 1) ? 1 : 2) * (8 << rc);
        if (r > 4)       req = "R3 clamped rate";
        else if (m == 1) req = "R4 doubled clock";
        else if (m == 0) req = "R2 base clock";
        else             req = "R5 reserved multiplier";
        check(req, n, exp);
      end
    end

    // R7: change right after a wrap; old period completes, then new applies
    rateSel = 3'd0; mulSel = 2'd1;
    waitPulse(n); waitPulse(n);
    rateSel = 3'd2; mulSel = 2'd0;
    waitPulse(n);
    check("R7 period in progress kept", n, 8);
    waitPulse(n);
    check("R7 new period applied", n, 64);
    // R6: pulse is one cycle wide
    @(negedge clk);
    check("R6 pulse width", int'(bitEn), 0);

    // Idle timer at fastest rate (8 cycles per bit)
    rateSel = 3'd0; mulSel = 2'd1;
    waitPulse(n); waitPulse(n);
    @(negedge clk);
    activity();
    check("R9 cleared after activity", int'(idleTimeout), 0);
    for (int i = 0; i < IDLE; i++) waitPulse(n);
    check("R8 not yet at last pulse", int'(idleTimeout), 0);
    @(negedge clk);
    check("R8 rises after last pulse", int'(idleTimeout), 1);
    repeat (40) @(negedge clk);
    check("R9 stays high while idle", int'(idleTimeout), 1);
    activity();
    check("R9 cleared by activity", int'(idleTimeout), 0);

    // R10: activity in the same cycle as the expiring pulse
    waitPulse(n);
    @(negedge clk);
    activity();
    for (int i = 0; i < IDLE - 1; i++) waitPulse(n);
    waitPulse(n);
    lineActive = 1'b1;
    @(negedge clk);
    lineActive = 1'b0;
    check("R10 coincident activity wins", int'(idleTimeout), 0);
    for (int i = 0; i < IDLE - 1; i++) waitPulse(n);
    @(negedge clk);
    check("R10 count restarted", int'(idleTimeout), 0);
    waitPulse(n);
    @(negedge clk);
    check("R10 expires after full run", int'(idleTimeout), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule